// File: doc/BRIEF.md
# Receive Character Queue with Line-Error Tags

This block buffers characters coming out of a serial receiver until software reads them. Every slot holds one 8-bit character together with three flags recorded when it was received: a break flag, a parity-error flag and a framing-error flag. The receiver pushes a character and its flags in one cycle. A read strobe from the register interface pops the oldest slot, whose contents are visible on the head outputs beforehand.

The block reports how many slots are occupied and raises a data-ready flag whenever anything is stored. It also raises a threshold flag that an interrupt controller can use. The threshold is picked by a 2-bit code. A summary flag is high while any stored slot carries an error flag. An overrun pulse marks a character that arrived while the queue was full. A clear input empties the queue in one cycle.

Top module: `rxq_fifo`

## Requirements
- R1: The queue holds up to 16 slots; `level` (0 to 16) equals accepted pushes minus accepted pops since the last reset or clear.
- R2: Slots leave in arrival order; the head outputs show the oldest slot's 8 data bits and its break, parity and framing flags unchanged.
- R3: A push and a pop in the same cycle both take effect, including when the queue is full, so `level` stays the same and no character is lost.
- R4: `data_ready` is high exactly when `level` is nonzero.
- R5: `trig_hit` is high when `level` is at least the threshold selected by `trig_code`: 2'b00 gives 1, 2'b01 gives 4, 2'b10 gives 8, 2'b11 gives 14.
- R6: A push into a full queue without a pop in the same cycle raises `overrun` for one cycle, starting in the cycle after the push. The incoming character is dropped, and the stored slots and `level` are unchanged.
- R7: `any_err` is high while at least one stored slot has one of its three flags set, and it falls once the last such slot is popped.
- R8: `clr` empties the queue at the next edge and overrides a push or pop in the same cycle, so that `level` becomes 0 and `any_err` and `overrun` become low.
- R9: A pop while the queue is empty has no effect.
- R10: After reset, `level` is 0 and `data_ready`, `trig_hit`, `any_err` and `overrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Empty the queue at the next edge |
| push | input | 1 | Write strobe from the receiver |
| push_data | input | 8 | Received character |
| push_brk | input | 1 | Break flag of the incoming character |
| push_perr | input | 1 | Parity-error flag of the incoming character |
| push_ferr | input | 1 | Framing-error flag of the incoming character |
| pop | input | 1 | Read strobe that removes the head slot |
| head_data | output | 8 | Character in the oldest slot |
| head_brk | output | 1 | Break flag of the oldest slot |
| head_perr | output | 1 | Parity flag of the oldest slot |
| head_ferr | output | 1 | Framing flag of the oldest slot |
| level | output | 5 | Number of occupied slots |
| data_ready | output | 1 | At least one slot occupied |
| trig_code | input | 2 | Threshold select |
| trig_hit | output | 1 | Level has reached the threshold |
| any_err | output | 1 | Some stored slot carries an error flag |
| overrun | output | 1 | One-cycle pulse: a character was dropped |

## Verification
The bench fills the queue from empty to full and, at every level, tries all four threshold codes. A wrong mapping or an off-by-one compare would show as `trig_hit` changing one slot early or late. It pushes into a full queue both with and without a simultaneous pop. A design that refuses the push in the combined case would lose a character or raise a false overrun, and one that accepts the push in the overrun case would corrupt the head or the level. The bench also drains the queue through slots with mixed error flags, to catch an `any_err` that sticks or clears too early. Finally, it pops an empty queue and issues a clear together with a push, checking that neither moves the pointers.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int CHAR_W = 8;

    typedef struct packed {
        logic              brk;
        logic              perr;
        logic              ferr;
        logic [CHAR_W-1:0] data;
    } rxq_slot_t;

    localparam int SLOT_W = $bits(rxq_slot_t);

    function automatic logic [4:0] trig_threshold(input logic [1:0] code);
        case (code)
            2'b00:   return 5'd1;
            2'b01:   return 5'd4;
            2'b10:   return 5'd8;
            default: return 5'd14;
        endcase
    endfunction

    function automatic logic slot_bad(input rxq_slot_t s);
        return s.brk | s.perr | s.ferr;
    endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int W     = 11,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             wr_req,
    input  logic [W-1:0]     wr_word,
    input  logic             rd_req,
    output logic [W-1:0]     rd_word,
    output logic             wr_acc,
    output logic             rd_acc,
    output logic [CNT_W-1:0] count,
    output logic             ovr
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic             full, empty;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign rd_acc  = rd_req & ~empty & ~clr;
    assign wr_acc  = wr_req & (~full | rd_acc) & ~clr;
    assign rd_word = mem[rp];

    always_ff @(posedge clk) begin
        if (wr_acc) mem[wp] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            ovr   <= 1'b0;
        end else begin
            if (wr_acc) wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (rd_acc) rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
            case ({wr_acc, rd_acc})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            ovr <= wr_req & full & ~rd_acc;
        end
    end

    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));
    assert_pushpop_level_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_req && rd_req && !clr && count != '0) |=> $stable(count));
    assert_drop_keeps_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !rd_req && !clr && full) |=> (count == CNT_W'(DEPTH)) && $stable(rp));
    assert_empty_pop_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !wr_req && !clr && empty) |=> (count == '0) && $stable(rp));
    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0) && !ovr);
endmodule

// File: rtl/rxq_errtrack.sv
module rxq_errtrack #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             in_acc,
    input  logic             in_bad,
    input  logic             out_acc,
    input  logic             out_bad,
    input  logic [CNT_W-1:0] level,
    output logic             any_bad
);
    logic [CNT_W-1:0] bad_cnt;
    logic             inc, dec;

    assign inc     = in_acc & in_bad;
    assign dec     = out_acc & out_bad;
    assign any_bad = (bad_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            bad_cnt <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   bad_cnt <= bad_cnt + 1'b1;
                2'b01:   bad_cnt <= bad_cnt - 1'b1;
                default: bad_cnt <= bad_cnt;
            endcase
        end
    end

    assert_err_within_level_R7: assert property (@(posedge clk) disable iff (rst)
        bad_cnt <= level);
    assert_err_clear_R8: assert property (@(posedge clk) disable iff (rst)
        clr |=> !any_bad);
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              push,
    input  logic [CHAR_W-1:0] push_data,
    input  logic              push_brk,
    input  logic              push_perr,
    input  logic              push_ferr,
    input  logic              pop,
    output logic [CHAR_W-1:0] head_data,
    output logic              head_brk,
    output logic              head_perr,
    output logic              head_ferr,
    output logic [CNT_W-1:0]  level,
    output logic              data_ready,
    input  logic [1:0]        trig_code,
    output logic              trig_hit,
    output logic              any_err,
    output logic              overrun
);
    rxq_slot_t in_slot, head_slot;
    logic      wr_acc, rd_acc;

    assign in_slot = '{brk: push_brk, perr: push_perr, ferr: push_ferr, data: push_data};

    rxq_store #(.DEPTH(DEPTH), .W(SLOT_W)) u_store (
        .clk(clk), .rst(rst), .clr(clr),
        .wr_req(push), .wr_word(in_slot),
        .rd_req(pop), .rd_word(head_slot),
        .wr_acc(wr_acc), .rd_acc(rd_acc),
        .count(level), .ovr(overrun)
    );

    rxq_errtrack #(.CNT_W(CNT_W)) u_err (
        .clk(clk), .rst(rst), .clr(clr),
        .in_acc(wr_acc), .in_bad(slot_bad(in_slot)),
        .out_acc(rd_acc), .out_bad(slot_bad(head_slot)),
        .level(level), .any_bad(any_err)
    );

    assign head_data  = head_slot.data;
    assign head_brk   = head_slot.brk;
    assign head_perr  = head_slot.perr;
    assign head_ferr  = head_slot.ferr;
    assign data_ready = (level != '0);
    assign trig_hit   = (level >= CNT_W'(trig_threshold(trig_code)));

    assert_err_needs_data_R7: assert property (@(posedge clk) disable iff (rst)
        any_err |-> data_ready);
    assert_trig_needs_data_R5: assert property (@(posedge clk) disable iff (rst)
        trig_hit |-> data_ready);
    assert_ovr_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        overrun |-> (level == CNT_W'(DEPTH)));
endmodule

// File: tb/sim_rxq_fifo.sv
`timescale 1ns/1ps
module sim_rxq_fifo;
    logic       clk = 0, rst = 1, clr = 0, push = 0, pop = 0;
    logic [7:0] push_data = 0;
    logic       push_brk = 0, push_perr = 0, push_ferr = 0;
    logic [1:0] trig_code = 0;
    logic [7:0] head_data;
    logic       head_brk, head_perr, head_ferr, data_ready, trig_hit, any_err, overrun;
    logic [4:0] level;

    int checks = 0, errors = 0;
    logic [10:0] q[$];
    bit exp_ovr = 0;

    always #10 clk = ~clk;

    rxq_fifo u0 (.*);

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int thr(input int c);
        return (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 14;
    endfunction

    task automatic check_all();
        bit e = 0;
        foreach (q[i]) if (q[i][10:8] != 0) e = 1;
        chk("R1 level", level, q.size());
        chk("R4 data_ready", data_ready, q.size() != 0);
        chk("R5 trig_hit", trig_hit, q.size() >= thr(trig_code));
        chk("R7 any_err", any_err, e);
        chk("R6 overrun", overrun, exp_ovr);
        if (q.size() != 0)
            chk("R2 head", {head_brk, head_perr, head_ferr, head_data}, q[0]);
    endtask

    // at negedge: drive, cross posedge, sample at next negedge
    task automatic step(input bit ps, input bit pp, input bit cl, input logic [10:0] e);
        bit popok;
        push = ps; pop = pp; clr = cl;
        {push_brk, push_perr, push_ferr, push_data} = e;
        if (cl) begin
            q.delete(); exp_ovr = 0;
        end else begin
            popok = pp && q.size() > 0;
            exp_ovr = ps && q.size() == 16 && !popok;
            if (popok) void'(q.pop_front());
            if (ps && !exp_ovr) q.push_back(e);
        end
        @(posedge clk); @(negedge clk);
        push = 0; pop = 0; clr = 0;
        check_all();
    endtask

    function automatic logic [10:0] pat(input int i);
        logic [2:0] f = (i % 5 == 3) ? 3'(1 << (i % 3)) : 3'b000;
        return {f, 8'(i * 37 + 5)};
    endfunction

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check_all(); // R10 reset state
        // R5 sweep of all codes at every level while filling (R1, R2)
        for (int i = 0; i < 16; i++) begin
            for (int c = 0; c < 4; c++) begin trig_code = 2'(c); #1 check_all(); end
            step(1, 0, 0, pat(i));
        end
        for (int c = 0; c < 4; c++) begin trig_code = 2'(c); #1 check_all(); end
        // R6 push into full without pop
        step(1, 0, 0, 11'h0AA);
        step(0, 0, 0, 0);
        // R3 push+pop at full
        step(1, 1, 0, pat(40));
        step(1, 1, 0, pat(43));
        // drain, R2 order and R7 error tracking
        while (q.size() > 0) step(0, 1, 0, 0);
        // R9 pop on empty
        step(0, 1, 0, 0);
        step(0, 1, 0, 0);
        // R3 at mid level
        for (int i = 0; i < 5; i++) step(1, 0, 0, pat(50 + i));
        for (int i = 0; i < 8; i++) step(1, 1, 0, pat(60 + i));
        // R8 clear overrides push
        step(1, 0, 1, pat(3));
        step(1, 0, 0, {3'b100, 8'h11});
        step(1, 1, 1, pat(7));
        step(0, 1, 0, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule